// File: doc/BRIEF.md
# Program Counter and Return Stack

This block holds the 12-bit fetch address of a small 4-bit controller and works out the next one. On each step strobe it moves the program counter according to a decoded control code. That code can be a plain advance, a short call to one of sixteen fixed entry points, a long call into the lower 2K words, a return, or an interrupt entry that jumps to the vector of its source. Fetch addresses stay within 000h to BFFh.

Calls and interrupt entries save a return address in a register stack of thirteen entries, and returns take it back. The stack pointer counts the occupied levels. Software may load it with a level number to choose where stacking begins. Two sticky flags record a push into a full stack and a return from an empty one. Instruction decode, program memory and interrupt priority live outside the block.

Top module: `pc_stack_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is cleared on each clock: `pc` = 000h, `sp` = 0, `ovf` = 0 and `unf` = 0.
- R2: A cycle with `step` high executes `op`, decoded as 0 = advance, 1 = short call, 2 = long call, 3 = return, 4 = interrupt entry, with 5 to 7 acting as advance. An advance sets `pc` to `pc`+1, wrapping from BFFh to 000h. Cycles with `step` low leave `pc` unchanged.
- R3: A short call sets `pc` to 00Eh + 8·`scall_idx`, so index 0 gives 00Eh and index 15 gives 086h. It saves `pc`+1 (wrapping from BFFh to 000h) as the return address.
- R4: A long call sets `pc` to the zero-extended 11-bit `lcall_tgt` and saves `pc`+1 as the return address.
- R5: An interrupt entry with `irq_src` of 0, 1, 2, 3 or 4 sets `pc` to 002h, 006h, 008h, 00Ah or 00Ch respectively. It saves the current `pc`, the address of the instruction not yet executed. With `irq_src` 5 to 7 the step acts as an advance and nothing is saved.
- R6: Each successful save writes the stack level numbered `sp` and then increments `sp`. A return with `sp` > 0 decrements `sp` and loads `pc` from the level it now points at, so returns come back in last-in, first-out order.
- R7: A save attempted when `sp` = 13 sets `ovf`. It leaves `sp` and all stored entries unchanged, but the jump is still taken.
- R8: A return with `sp` = 0 sets `unf`, leaves `sp` at 0 and advances `pc` by one.
- R9: With `step` low, `sp_wr` high loads `sp` from `sp_wdata` when the value is 0 to 12. Values 13 to 15 are ignored, and `sp_wr` is ignored in any cycle where `step` is high.
- R10: Once set, `ovf` and `unf` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Execute `op` this cycle |
| op | input | 3 | Control code |
| scall_idx | input | 4 | Short-call entry index |
| lcall_tgt | input | 11 | Long-call target |
| irq_src | input | 3 | Interrupt source code |
| sp_wr | input | 1 | Stack pointer load strobe |
| sp_wdata | input | 4 | Stack pointer load value |
| pc | output | 12 | Current fetch address |
| sp | output | 4 | Occupied stack levels |
| ovf | output | 1 | Sticky stack overflow flag |
| unf | output | 1 | Sticky stack underflow flag |

## Verification
The assertions check the cycle-local rules on every cycle. These are the target address after an advance, short call, long call or interrupt entry; the range of `pc` and `sp`; the holding of state on idle cycles; the one-step change of `sp` on pushes and pops; and the stickiness of both flags. Some behaviours need a sequence of operations to show, and only the bench scenarios can show them. These are the values stored on the stack and returned later, including the wrapped return address from BFFh and the unadvanced address saved on interrupt entry. They also include the rule that an overflowing push leaves the stored entries intact, and the rejection of out-of-range or colliding stack pointer loads.

// File: rtl/pc_stack_ctrl.sv
module pc_stack_ctrl #(
  parameter int PC_W      = 12,
  parameter int LAST_ADDR = 'hBFF,
  parameter int DEPTH     = 13,
  parameter int IDX_W     = 4,
  parameter int LONG_W    = 11,
  parameter int SRC_W     = 3,
  parameter int SP_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [2:0]        op,
  input  logic [IDX_W-1:0]  scall_idx,
  input  logic [LONG_W-1:0] lcall_tgt,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic              sp_wr,
  input  logic [SP_W-1:0]   sp_wdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic              ovf,
  output logic              unf
);
  localparam logic [2:0] OP_SCALL = 3'd1;
  localparam logic [2:0] OP_LCALL = 3'd2;
  localparam logic [2:0] OP_RET   = 3'd3;
  localparam logic [2:0] OP_IRQ   = 3'd4;
  localparam logic [PC_W-1:0] LAST     = PC_W'(LAST_ADDR);
  localparam logic [PC_W-1:0] SC_BASE  = PC_W'(14);
  localparam logic [SP_W-1:0] FULL     = SP_W'(DEPTH);
  localparam logic [SP_W-1:0] LOAD_MAX = SP_W'(DEPTH - 1);

  logic [PC_W-1:0] pc_q, pc_inc, vec, ret_addr, target;
  logic [SP_W-1:0] sp_q;
  logic            ovf_q, unf_q;
  logic [PC_W-1:0] stk [DEPTH];
  logic            vec_ok, do_push, do_ret, full, empty;

  assign pc_inc = (pc_q == LAST) ? '0 : pc_q + 1'b1;
  assign full   = (sp_q == FULL);
  assign empty  = (sp_q == '0);

  always_comb begin
    vec_ok = 1'b1;
    case (irq_src)
      SRC_W'(0): vec = PC_W'('h002);
      SRC_W'(1): vec = PC_W'('h006);
      SRC_W'(2): vec = PC_W'('h008);
      SRC_W'(3): vec = PC_W'('h00A);
      SRC_W'(4): vec = PC_W'('h00C);
      default: begin vec = '0; vec_ok = 1'b0; end
    endcase
  end

  always_comb begin
    do_push  = 1'b0;
    do_ret   = 1'b0;
    ret_addr = pc_inc;
    target   = pc_inc;
    if (step) begin
      case (op)
        OP_SCALL: begin
          do_push = 1'b1;
          target  = SC_BASE + (PC_W'(scall_idx) << 3);
        end
        OP_LCALL: begin
          do_push = 1'b1;
          target  = PC_W'(lcall_tgt);
        end
        OP_RET: begin
          do_ret = 1'b1;
          if (!empty) target = stk[sp_q - 1'b1];
        end
        OP_IRQ: if (vec_ok) begin
          do_push  = 1'b1;
          ret_addr = pc_q;
          target   = vec;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (step) begin
      pc_q <= target;
      if (do_push) begin
        if (full) ovf_q <= 1'b1;
        else      sp_q  <= sp_q + 1'b1;
      end
      if (do_ret) begin
        if (empty) unf_q <= 1'b1;
        else       sp_q  <= sp_q - 1'b1;
      end
    end else if (sp_wr && sp_wdata <= LOAD_MAX) begin
      sp_q <= sp_wdata;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      always_ff @(posedge clk)
        if (rst_n && do_push && sp_q == SP_W'(i)) stk[i] <= ret_addr;
    end
  endgenerate

  assign pc  = pc_q;
  assign sp  = sp_q;
  assign ovf = ovf_q;
  assign unf = unf_q;
endmodule

module pc_stack_ctrl_chk #(
  parameter int PC_W = 12, parameter int LAST_ADDR = 'hBFF, parameter int DEPTH = 13,
  parameter int IDX_W = 4, parameter int LONG_W = 11, parameter int SRC_W = 3,
  parameter int SP_W = 4
) (
  input logic clk, rst_n, step,
  input logic [2:0] op,
  input logic [IDX_W-1:0] scall_idx,
  input logic [LONG_W-1:0] lcall_tgt,
  input logic [SRC_W-1:0] irq_src,
  input logic sp_wr,
  input logic [SP_W-1:0] sp_wdata,
  input logic [PC_W-1:0] pc,
  input logic [SP_W-1:0] sp,
  input logic ovf, unf
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (pc == '0 && sp == '0 && !ovf && !unf));
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (op == 3'd0 || op > 3'd4)) |=>
      (pc == (($past(pc) == PC_W'(LAST_ADDR)) ? '0 : $past(pc) + 1'b1)));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n) !step |=> $stable(pc));
  p_pc_range_r2: assert property (@(posedge clk) disable iff (!rst_n) pc <= PC_W'(LAST_ADDR));
  p_scall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd1) |=> (pc == PC_W'(8 * $past(scall_idx) + 14)));
  p_lcall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd2) |=> (pc == PC_W'($past(lcall_tgt))));
  p_int1_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd4 && irq_src == SRC_W'(4)) |=> (pc == PC_W'('h00C)));
  p_int0_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd4 && irq_src == SRC_W'(0)) |=> (pc == PC_W'('h002)));
  p_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (op == 3'd1 || op == 3'd2) && sp != SP_W'(DEPTH)) |=> (sp == $past(sp) + 1'b1));
  p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd3 && sp != '0) |=> (sp == $past(sp) - 1'b1));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd2 && sp == SP_W'(DEPTH)) |=> (ovf && $stable(sp)));
  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd3 && sp == '0) |=> (unf && sp == '0));
  p_sp_range_r9: assert property (@(posedge clk) disable iff (!rst_n) sp <= SP_W'(DEPTH));
  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n) (!step && !sp_wr) |=> $stable(sp));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n) unf |=> unf);
endmodule

bind pc_stack_ctrl pc_stack_ctrl_chk #(
  .PC_W(PC_W), .LAST_ADDR(LAST_ADDR), .DEPTH(DEPTH), .IDX_W(IDX_W),
  .LONG_W(LONG_W), .SRC_W(SRC_W), .SP_W(SP_W)
) u_chk (.*);

// File: tb/sim_pc_stack_ctrl.sv
module sim_pc_stack_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, sp_wr = 1'b0;
  logic [2:0] op = '0, irq_src = '0;
  logic [3:0] scall_idx = '0, sp_wdata = '0, sp;
  logic [10:0] lcall_tgt = '0;
  logic [11:0] pc;
  logic ovf, unf;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pc_stack_ctrl u0 (.clk, .rst_n, .step, .op, .scall_idx, .lcall_tgt, .irq_src,
                    .sp_wr, .sp_wdata, .pc, .sp, .ovf, .unf);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(logic [2:0] o, int arg = 0);
    @(negedge clk);
    step = 1'b1; op = o;
    scall_idx = 4'(arg); lcall_tgt = 11'(arg); irq_src = 3'(arg);
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic load_sp(int v, bit with_step = 1'b0);
    @(negedge clk);
    sp_wr = 1'b1; sp_wdata = 4'(v); step = with_step; op = '0;
    @(negedge clk);
    sp_wr = 1'b0; step = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pc", int'(pc), 0); chk("R1 sp", int'(sp), 0);
    chk("R1 ovf", int'(ovf), 0); chk("R1 unf", int'(unf), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_seq;
    repeat (3) run(3'd0);
    chk("R2 advance", int'(pc), 3);
    repeat (3) @(negedge clk);
    chk("R2 idle hold", int'(pc), 3);
    run(3'd6);
    chk("R2 code 6 advances", int'(pc), 4);
    load_sp(0);
  endtask

  task automatic t_scall;
    run(3'd1, 5);
    chk("R3 scall idx5", int'(pc), 'h036); chk("R6 sp push", int'(sp), 1);
    run(3'd1, 15);
    chk("R3 scall idx15", int'(pc), 'h086);
    run(3'd1, 0);
    chk("R3 scall idx0", int'(pc), 'h00E); chk("R6 sp 3", int'(sp), 3);
    run(3'd3);
    chk("R6 ret lifo 1", int'(pc), 'h087);
    run(3'd3);
    chk("R6 ret lifo 2", int'(pc), 'h037);
    run(3'd3);
    chk("R6 ret lifo 3", int'(pc), 5); chk("R6 sp back", int'(sp), 0);
  endtask

  task automatic t_lcall_wrap;
    run(3'd2, 'h7FF);
    chk("R4 lcall", int'(pc), 'h7FF); chk("R4 sp", int'(sp), 1);
    repeat (1024) run(3'd0);
    chk("R2 reach last", int'(pc), 'hBFF);
    run(3'd1, 2);
    chk("R3 scall from last", int'(pc), 'h01E);
    run(3'd3);
    chk("R3 wrapped return", int'(pc), 0);
    run(3'd2, 'h7FF);
    repeat (1024) run(3'd0);
    run(3'd0);
    chk("R2 wrap to 0", int'(pc), 0);
    run(3'd3);
    chk("R4 ret", int'(pc), 1);
    run(3'd3);
    chk("R4 ret outer", int'(pc), 6); chk("R4 sp 0", int'(sp), 0);
  endtask

  task automatic t_irq;
    int vecs[5] = '{'h002, 'h006, 'h008, 'h00A, 'h00C};
    for (int s = 0; s < 5; s++) begin
      int here = int'(pc);
      run(3'd4, s);
      chk("R5 vector", int'(pc), vecs[s]); chk("R5 sp", int'(sp), 1);
      run(3'd3);
      chk("R5 unadvanced return", int'(pc), here);
      run(3'd0);
    end
    begin
      int here = int'(pc);
      run(3'd4, 6);
      chk("R5 bad src advances", int'(pc), here + 1); chk("R5 bad src no push", int'(sp), 0);
    end
  endtask

  task automatic t_spload;
    load_sp(7);
    chk("R9 load 7", int'(sp), 7);
    load_sp(13);
    chk("R9 ignore 13", int'(sp), 7);
    load_sp(15);
    chk("R9 ignore 15", int'(sp), 7);
    load_sp(3, 1'b1);
    chk("R9 ignored with step", int'(sp), 7);
    run(3'd2, 'h123);
    chk("R9 push from 7", int'(sp), 8);
    load_sp(0);
  endtask

  task automatic t_ovf;
    int here;
    load_sp(12);
    here = int'(pc);
    run(3'd2, 'h200);
    chk("R7 last level ok", int'(sp), 13); chk("R7 no ovf yet", int'(ovf), 0);
    run(3'd2, 'h300);
    chk("R7 jump taken", int'(pc), 'h300); chk("R7 ovf set", int'(ovf), 1);
    chk("R7 sp held", int'(sp), 13);
    run(3'd4, 1);
    chk("R7 irq jump taken", int'(pc), 'h006); chk("R7 sp still 13", int'(sp), 13);
    run(3'd3);
    chk("R7 entry intact", int'(pc), here + 1); chk("R7 sp 12", int'(sp), 12);
    repeat (3) run(3'd0);
    chk("R10 ovf sticky", int'(ovf), 1);
  endtask

  task automatic t_unf;
    int here;
    load_sp(0);
    here = int'(pc);
    run(3'd3);
    chk("R8 unf set", int'(unf), 1); chk("R8 sp 0", int'(sp), 0);
    chk("R8 pc advance", int'(pc), here + 1);
    run(3'd1, 1);
    run(3'd3);
    chk("R10 unf sticky", int'(unf), 1);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_seq();
    t_scall();
    t_lcall_wrap();
    t_irq();
    t_spload();
    t_ovf();
    t_unf();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule